// File: doc/BRIEF.md
# Byte-Lane Sequencer for a 16-bit Memory Bus

This block turns byte or word requests from a processor into cycles on a 16-bit external memory bus. The request side uses a 20-bit byte address, so it covers 1 MiB. The bus side drives a 19-bit word address, a lane-select bit `bus_a0` and an active-low high-lane enable `bus_bhe_n`. Together these two signals choose the low lane, the high lane, or both lanes. A word at an odd byte address does not fit in one bus word, so the block splits it into two aligned cycles. It then packs the bytes it keeps into a single result. Byte order is little-endian: the lower byte address always holds the less significant byte.

A request is taken only in state `ST_IDLE`, and taking it moves the block to `ST_FIRST`. In `ST_FIRST`, a cycle that completes goes to `ST_SECOND` if the access needs a second cycle, and to `ST_DONE` if it does not. In `ST_SECOND`, a completed cycle goes to `ST_DONE`. `ST_DONE` lasts one clock, pulses `done`, and returns to `ST_IDLE`. A bus cycle completes on the clock edge where `bus_ready` is sampled high. Until then it holds every bus output.

Top module: `bls_bus_sequencer`

## Requirements
- R1: Even-address byte access: one cycle with `bus_a0`=0 and `bus_bhe_n`=1, at `bus_waddr` = `req_addr[19:1]`. On a write, the byte is driven on `bus_wdata[7:0]`. On a read, the byte is taken from `bus_rdata[7:0]`.
- R2: Odd-address byte access: one cycle with `bus_a0`=1 and `bus_bhe_n`=0, at `req_addr[19:1]`. On a write, the byte is driven on `bus_wdata[15:8]`. On a read, the byte is taken from `bus_rdata[15:8]`.
- R3: Even-address word access: one cycle with `bus_a0`=0 and `bus_bhe_n`=0, at `req_addr[19:1]`. Bits 7:0 carry the byte at the lower address, which is the less significant byte. The read result is `bus_rdata`, and write data is driven unchanged.
- R4: While `bus_cyc` is high, the pair `bus_a0`=1 with `bus_bhe_n`=1 is never driven.
- R5: Odd-address word read at N: two full-width reads (`bus_a0`=0, `bus_bhe_n`=0). The first is at word N>>1 and the second at (N>>1)+1, wrapping modulo 2^19. The result is {second[7:0], first[15:8]}. The bytes at N-1 and N+2 are dropped.
- R6: Odd-address word write at N: first a high-lane cycle at N>>1 (`bus_a0`=1, `bus_bhe_n`=0) with `req_wdata[7:0]` on bits 15:8. Then a low-lane cycle at (N>>1)+1 (`bus_a0`=0, `bus_bhe_n`=1) with `req_wdata[15:8]` on bits 7:0.
- R7: While a cycle waits for `bus_ready`, `bus_waddr`, `bus_a0`, `bus_bhe_n`, `bus_we` and `bus_wdata` stay unchanged.
- R8: `done` is high for exactly one clock, the clock after the edge where the last cycle's `bus_ready` is sampled. A request presented at a negedge gives `done` at the n·(W+1)+1-th following negedge, where n is the number of cycles and W the wait clocks per cycle. `busy` is high from acceptance through `done`. A `req_valid` seen while `busy` is ignored.
- R9: Byte reads return the byte zero-extended on `rd_result` (bits 15:8 are 0).
- R10: After reset and between requests, `bus_cyc`, `bus_a0`, `busy` and `done` are 0 and `bus_bhe_n` is 1. During each cycle, `bus_we` equals the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte access uses bits 7:0 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_result | output | 16 | Assembled read data, held after `done` |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_waddr | output | 19 | Word address on the bus |
| bus_a0 | output | 1 | Low-lane select (0 = low lane in use) |
| bus_bhe_n | output | 1 | High-lane enable, active low |
| bus_we | output | 1 | Bus cycle is a write |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Memory ready; completes the cycle when sampled high |

## Verification
The bench targets odd-address words, since they show the most ways to go wrong:
- A design that forgot the split would issue one misaligned cycle.
- A design that swapped the halves would return the bytes in big-endian order.
- A design that reused the first word address for the second cycle would fetch the wrong data.

An odd word at the top of the address space checks that the second word address wraps to zero rather than saturating. Wait states of several clocks check that the bus outputs stay held. They also check that read data is sampled only on the ready edge, because the bus model drives junk at every other time. A request raised in mid-transfer checks that a design does not start a second, stray cycle.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } bls_state_e;

    typedef enum logic [1:0] {
        ACC_BYTE_EVEN,
        ACC_BYTE_ODD,
        ACC_WORD_EVEN,
        ACC_WORD_ODD
    } bls_acc_e;

endpackage

// File: rtl/bls_lane_plan.sv
module bls_lane_plan #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                is_word,
    input  logic                is_write,
    input  logic [DATA_W-1:0]   wdata,
    output bls_pkg::bls_acc_e   acc,
    output logic                two_cyc,
    output logic [ADDR_W-2:0]   c0_waddr,
    output logic                c0_a0,
    output logic                c0_bhe_n,
    output logic [DATA_W-1:0]   c0_wdata,
    output logic [ADDR_W-2:0]   c1_waddr,
    output logic                c1_a0,
    output logic                c1_bhe_n,
    output logic [DATA_W-1:0]   c1_wdata
);
    import bls_pkg::*;

    localparam int WA_W   = ADDR_W - 1;
    localparam int LANE_W = DATA_W / 2;

    logic [WA_W-1:0]   base;
    logic [LANE_W-1:0] lo_b;
    logic [LANE_W-1:0] hi_b;

    assign base = addr[ADDR_W-1:1];
    assign lo_b = wdata[LANE_W-1:0];
    assign hi_b = wdata[DATA_W-1:LANE_W];

    always_comb begin
        acc      = ACC_BYTE_EVEN;
        two_cyc  = 1'b0;
        c0_waddr = base;
        c0_a0    = 1'b0;
        c0_bhe_n = 1'b1;
        c0_wdata = {lo_b, lo_b};
        c1_waddr = base + WA_W'(1);
        c1_a0    = 1'b0;
        c1_bhe_n = 1'b1;
        c1_wdata = {hi_b, hi_b};
        unique case ({is_word, addr[0]})
            2'b00: begin
                acc = ACC_BYTE_EVEN;
            end
            2'b01: begin
                acc      = ACC_BYTE_ODD;
                c0_a0    = 1'b1;
                c0_bhe_n = 1'b0;
            end
            2'b10: begin
                acc      = ACC_WORD_EVEN;
                c0_bhe_n = 1'b0;
                c0_wdata = wdata;
            end
            2'b11: begin
                acc     = ACC_WORD_ODD;
                two_cyc = 1'b1;
                if (is_write) begin
                    c0_a0    = 1'b1;
                    c0_bhe_n = 1'b0;
                    c1_a0    = 1'b0;
                    c1_bhe_n = 1'b1;
                end else begin
                    c0_a0    = 1'b0;
                    c0_bhe_n = 1'b0;
                    c1_a0    = 1'b0;
                    c1_bhe_n = 1'b0;
                end
            end
            default: begin
                acc = ACC_BYTE_EVEN;
            end
        endcase
    end

endmodule

// File: rtl/bls_read_merge.sv
module bls_read_merge #(
    parameter int DATA_W = 16
) (
    input  bls_pkg::bls_acc_e   acc,
    input  logic                second,
    input  logic [DATA_W-1:0]   rd,
    input  logic [DATA_W-1:0]   prev,
    output logic [DATA_W-1:0]   merged
);
    import bls_pkg::*;

    localparam int LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] rd_lo;
    logic [LANE_W-1:0] rd_hi;

    assign rd_lo = rd[LANE_W-1:0];
    assign rd_hi = rd[DATA_W-1:LANE_W];

    always_comb begin
        merged = prev;
        unique case (acc)
            ACC_BYTE_EVEN: merged = {{LANE_W{1'b0}}, rd_lo};
            ACC_BYTE_ODD:  merged = {{LANE_W{1'b0}}, rd_hi};
            ACC_WORD_EVEN: merged = rd;
            ACC_WORD_ODD: begin
                if (second)
                    merged = {rd_lo, prev[LANE_W-1:0]};
                else
                    merged = {prev[DATA_W-1:LANE_W], rd_hi};
            end
            default: merged = prev;
        endcase
    end

endmodule

// File: rtl/bls_bus_sequencer.sv
module bls_bus_sequencer #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_word,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rd_result,
    output logic                bus_cyc,
    output logic [ADDR_W-2:0]   bus_waddr,
    output logic                bus_a0,
    output logic                bus_bhe_n,
    output logic                bus_we,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ready
);
    import bls_pkg::*;

    localparam int WA_W = ADDR_W - 1;

    bls_state_e state, state_nxt;

    bls_acc_e          acc_d, acc_q;
    logic              two_d, two_q;
    logic              we_q;
    logic [WA_W-1:0]   c0_waddr_d, c0_waddr_q, c1_waddr_d, c1_waddr_q;
    logic              c0_a0_d, c0_a0_q, c1_a0_d, c1_a0_q;
    logic              c0_bhe_d, c0_bhe_q, c1_bhe_d, c1_bhe_q;
    logic [DATA_W-1:0] c0_wd_d, c0_wd_q, c1_wd_d, c1_wd_q;
    logic [DATA_W-1:0] res_q, res_merged;
    logic              accept, cyc_end;

    bls_lane_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
        .addr     (req_addr),
        .is_word  (req_word),
        .is_write (req_write),
        .wdata    (req_wdata),
        .acc      (acc_d),
        .two_cyc  (two_d),
        .c0_waddr (c0_waddr_d),
        .c0_a0    (c0_a0_d),
        .c0_bhe_n (c0_bhe_d),
        .c0_wdata (c0_wd_d),
        .c1_waddr (c1_waddr_d),
        .c1_a0    (c1_a0_d),
        .c1_bhe_n (c1_bhe_d),
        .c1_wdata (c1_wd_d)
    );

    bls_read_merge #(.DATA_W(DATA_W)) u_merge (
        .acc    (acc_q),
        .second (state == ST_SECOND),
        .rd     (bus_rdata),
        .prev   (res_q),
        .merged (res_merged)
    );

    assign accept  = (state == ST_IDLE) && req_valid;
    assign cyc_end = ((state == ST_FIRST) || (state == ST_SECOND)) && bus_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nxt = ST_FIRST;
            ST_FIRST:  if (bus_ready) state_nxt = two_q ? ST_SECOND : ST_DONE;
            ST_SECOND: if (bus_ready) state_nxt = ST_DONE;
            ST_DONE:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= ACC_BYTE_EVEN;
            two_q      <= 1'b0;
            we_q       <= 1'b0;
            c0_waddr_q <= '0;
            c0_a0_q    <= 1'b0;
            c0_bhe_q   <= 1'b1;
            c0_wd_q    <= '0;
            c1_waddr_q <= '0;
            c1_a0_q    <= 1'b0;
            c1_bhe_q   <= 1'b1;
            c1_wd_q    <= '0;
        end else if (accept) begin
            acc_q      <= acc_d;
            two_q      <= two_d;
            we_q       <= req_write;
            c0_waddr_q <= c0_waddr_d;
            c0_a0_q    <= c0_a0_d;
            c0_bhe_q   <= c0_bhe_d;
            c0_wd_q    <= c0_wd_d;
            c1_waddr_q <= c1_waddr_d;
            c1_a0_q    <= c1_a0_d;
            c1_bhe_q   <= c1_bhe_d;
            c1_wd_q    <= c1_wd_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (cyc_end && !we_q)
            res_q <= res_merged;
    end

    always_comb begin
        bus_cyc   = 1'b0;
        bus_waddr = c0_waddr_q;
        bus_a0    = 1'b0;
        bus_bhe_n = 1'b1;
        bus_we    = 1'b0;
        bus_wdata = '0;
        busy      = (state != ST_IDLE);
        done      = 1'b0;
        rd_result = res_q;
        unique case (state)
            ST_FIRST: begin
                bus_cyc   = 1'b1;
                bus_waddr = c0_waddr_q;
                bus_a0    = c0_a0_q;
                bus_bhe_n = c0_bhe_q;
                bus_we    = we_q;
                bus_wdata = we_q ? c0_wd_q : '0;
            end
            ST_SECOND: begin
                bus_cyc   = 1'b1;
                bus_waddr = c1_waddr_q;
                bus_a0    = c1_a0_q;
                bus_bhe_n = c1_bhe_q;
                bus_we    = we_q;
                bus_wdata = we_q ? c1_wd_q : '0;
            end
            ST_DONE: done = 1'b1;
            ST_IDLE: done = 1'b0;
            default: done = 1'b0;
        endcase
    end

endmodule

// File: rtl/bls_bus_sequencer_chk.sv
module bls_bus_sequencer_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_cyc,
    input logic [ADDR_W-2:0] bus_waddr,
    input logic              bus_a0,
    input logic              bus_bhe_n,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready
);

    assert_no_illegal_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !(bus_a0 && bus_bhe_n));

    assert_hold_while_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_waddr) && $stable(bus_a0)
                                     && $stable(bus_bhe_n) && $stable(bus_we)
                                     && $stable(bus_wdata)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_cyc && bus_ready));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_cyc && !done));

    assert_second_word_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc && bus_ready)) |-> (bus_waddr == $past(bus_waddr) + 1'b1));

    assert_split_write_low_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && $past(bus_cyc && bus_ready)) |-> (!bus_a0 && bus_bhe_n));

endmodule

bind bls_bus_sequencer bls_bus_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_cyc   (bus_cyc),
    .bus_waddr (bus_waddr),
    .bus_a0    (bus_a0),
    .bus_bhe_n (bus_bhe_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/tb_bls_bus_sequencer.sv
`timescale 1ns/1ps
module tb_bls_bus_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_result;
    logic        bus_cyc;
    logic [18:0] bus_waddr;
    logic        bus_a0, bus_bhe_n, bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ready;

    always #2 clk = ~clk;

    bls_bus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_result(rd_result), .bus_cyc(bus_cyc),
        .bus_waddr(bus_waddr), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bus model state and cycle log
    int          wait_cfg = 0;
    int          ncyc = 0;
    int          illegal_cnt = 0;
    int          stab_err = 0;
    logic [18:0] lg_waddr [4];
    logic        lg_a0 [4];
    logic        lg_bhe [4];
    logic        lg_we [4];
    logic [15:0] lg_wd [4];

    function automatic logic [15:0] mem_word(input logic [18:0] w);
        return {w[7:0] ^ 8'hC3, w[7:0] + 8'h11};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        int cnt = 0;
        logic [18:0] s_wa;
        logic s_a0, s_bhe, s_we;
        logic [15:0] s_wd;
        bus_ready = 1'b0;
        bus_rdata = 16'hDEAD;
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0;
                bus_rdata = 16'hDEAD;
                cnt = 0;
            end
            if (rst_n && bus_cyc) begin
                if (bus_a0 && bus_bhe_n) illegal_cnt++;
                if (cnt == 0) begin
                    s_wa = bus_waddr; s_a0 = bus_a0; s_bhe = bus_bhe_n;
                    s_we = bus_we; s_wd = bus_wdata;
                end else if (s_wa !== bus_waddr || s_a0 !== bus_a0 || s_bhe !== bus_bhe_n
                             || s_we !== bus_we || s_wd !== bus_wdata) begin
                    stab_err++;
                end
                if (cnt >= wait_cfg) begin
                    bus_ready = 1'b1;
                    bus_rdata = mem_word(bus_waddr);
                    if (ncyc < 4) begin
                        lg_waddr[ncyc] = bus_waddr; lg_a0[ncyc] = bus_a0;
                        lg_bhe[ncyc] = bus_bhe_n; lg_we[ncyc] = bus_we;
                        lg_wd[ncyc] = bus_wdata;
                    end
                    ncyc++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // issue one request at a negedge and wait for done; returns negedges to done
    task automatic run_req(input logic [19:0] a, input logic w, input logic wr,
                           input logic [15:0] d, input int waits, output int lat);
        ncyc = 0;
        wait_cfg = waits;
        lat = 0;
        @(negedge clk);
        req_addr = a; req_word = w; req_write = wr; req_wdata = d; req_valid = 1'b1;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic check_req(input logic [19:0] a, input logic w, input logic wr,
                             input logic [15:0] d, input int waits, input int lat);
        logic [18:0] base, nb;
        logic [15:0] mb, mn, exp_rd;
        string rq;
        int n;
        base = a[19:1];
        nb = base + 19'd1;
        mb = mem_word(base);
        mn = mem_word(nb);
        n = (w && a[0]) ? 2 : 1;
        rq = !w ? (a[0] ? "R2" : "R1") : (!a[0] ? "R3" : (wr ? "R6" : "R5"));
        chk(rq, "cycle count", ncyc, n);
        chk(waits > 0 ? "R7" : "R8", "latency to done", lat, n * (waits + 1) + 1);
        for (int i = 0; i < n && i < ncyc; i++)
            chk("R10", "bus_we", lg_we[i], wr);
        if (ncyc >= 1) chk(rq, "first waddr", lg_waddr[0], base);
        if (!w && !a[0] && ncyc >= 1) begin
            chk("R1", "a0/bhe_n", {lg_a0[0], lg_bhe[0]}, 2'b01);
            if (wr) chk("R1", "low lane data", lg_wd[0][7:0], d[7:0]);
            exp_rd = {8'h00, mb[7:0]};
        end else if (!w && a[0] && ncyc >= 1) begin
            chk("R2", "a0/bhe_n", {lg_a0[0], lg_bhe[0]}, 2'b10);
            if (wr) chk("R2", "high lane data", lg_wd[0][15:8], d[7:0]);
            exp_rd = {8'h00, mb[15:8]};
        end else if (w && !a[0] && ncyc >= 1) begin
            chk("R3", "a0/bhe_n", {lg_a0[0], lg_bhe[0]}, 2'b00);
            if (wr) chk("R3", "word data", lg_wd[0], d);
            exp_rd = mb;
        end else if (ncyc >= 2) begin
            chk(rq, "second waddr", lg_waddr[1], nb);
            if (wr) begin
                chk("R6", "first a0/bhe_n", {lg_a0[0], lg_bhe[0]}, 2'b10);
                chk("R6", "first high lane", lg_wd[0][15:8], d[7:0]);
                chk("R6", "second a0/bhe_n", {lg_a0[1], lg_bhe[1]}, 2'b01);
                chk("R6", "second low lane", lg_wd[1][7:0], d[15:8]);
            end else begin
                chk("R5", "first a0/bhe_n", {lg_a0[0], lg_bhe[0]}, 2'b00);
                chk("R5", "second a0/bhe_n", {lg_a0[1], lg_bhe[1]}, 2'b00);
            end
            exp_rd = {mn[7:0], mb[15:8]};
        end else begin
            exp_rd = 16'h0000;
        end
        if (!wr) chk(w ? rq : "R9", "read result", rd_result, exp_rd);
        @(negedge clk);
        chk("R8", "done/busy after pulse", {done, busy}, 2'b00);
    endtask

    // {addr[19:0], word, write, wdata[15:0], waits[1:0]}
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {20'h00A10, 1'b0, 1'b0, 16'h0000, 2'd0},
        {20'h00A11, 1'b0, 1'b0, 16'h0000, 2'd1},
        {20'h01234, 1'b1, 1'b0, 16'h0000, 2'd2},
        {20'h01235, 1'b1, 1'b0, 16'h0000, 2'd0},
        {20'h00020, 1'b0, 1'b1, 16'h1234, 2'd0},
        {20'h00021, 1'b0, 1'b1, 16'h5678, 2'd2},
        {20'h00044, 1'b1, 1'b1, 16'hBEEF, 2'd0},
        {20'h00047, 1'b1, 1'b1, 16'hCAFE, 2'd1},
        {20'hFFFFF, 1'b1, 1'b0, 16'h0000, 2'd3},
        {20'hFFFFF, 1'b1, 1'b1, 16'hA55A, 2'd0},
        {20'h7FFFF, 1'b0, 1'b0, 16'h0000, 2'd0}
    };

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk("R10", "reset state busy/done/cyc/a0/bhe_n",
            {busy, done, bus_cyc, bus_a0, bus_bhe_n}, 5'b00001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle after reset", {busy, done, bus_cyc, bus_a0, bus_bhe_n}, 5'b00001);

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][39:20], VEC[v][19], VEC[v][18], VEC[v][17:2], int'(VEC[v][1:0]), lat);
            check_req(VEC[v][39:20], VEC[v][19], VEC[v][18], VEC[v][17:2], int'(VEC[v][1:0]), lat);
        end

        // R8: a request raised while busy is ignored
        ncyc = 0;
        wait_cfg = 3;
        @(negedge clk);
        req_addr = 20'h00300; req_word = 1'b1; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_addr = 20'h00551; req_word = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 12; k++) @(negedge clk);
        chk("R8", "cycles for busy-time request", ncyc, 1);
        chk("R8", "waddr of accepted request", lg_waddr[0], 19'h00180);
        chk("R8", "idle after ignored request", {busy, bus_cyc}, 2'b00);

        chk("R4", "illegal lane pairs seen", illegal_cnt, 0);
        chk("R7", "outputs changed during wait", stab_err, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule